// File: doc/BRIEF.md
# Double-Buffered Colour Palette

This block holds the colour palette for an 8-bit indexed pixel mode. It keeps two banks of 256 entries, each 24 bits wide and packed as red in bits 23:16, green in 15:8 and blue in 7:0. In every cycle one bank turns an incoming pixel index into an RGB value for the display pipeline. Software fills the other bank through a small register port, so a new palette can be built while the current one is still on screen.

The control register carries a request bit (bit 0), which software sets, and a status bit (bit 1), which only the hardware sets. Software toggles the request bit to ask for a bank swap. The swap takes effect only on a frame-boundary strobe, so a frame never shows colours from both banks. The status bit names the bank on display. When status equals request, the last swap is done: software may refill the hidden bank and toggle the request bit again. Palette entry n is at the table base address plus 4·n. The control register is at address 0.

Top module: `palette_dbuf`

## Requirements
- R1: After reset the control register reads 0 (request 0, status 0). Bank 0 is on display and table writes go to bank 1.
- R2: A write to table base + 4·n (base 0x400, n in 0..255) stores the 24-bit data in entry n of the bank that is not on display. A read of the same address returns that entry one cycle after the read strobe.
- R3: The pixel output shows the entry of the displayed bank selected by the pixel index. It is registered, so the value appears one cycle after the index is presented.
- R4: Table writes never change the colours produced by the displayed bank.
- R5: A control write sets the request bit (bit 0) from data bit 0. The status bit and the displayed bank stay unchanged until a frame-boundary strobe.
- R6: On a frame-boundary strobe while request differs from status, the status bit takes the request value in the next cycle. From then on the pixel output uses the newly selected bank.
- R7: A frame-boundary strobe while request equals status changes nothing.
- R8: A control read returns status in bit 1 and request in bit 0, with all other bits zero. A write to bit 1 has no effect on status.
- R9: Writes are ignored, and reads return 0, at addresses that are neither the control register nor a word-aligned table entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 11 | Byte address of the register access |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data, valid the cycle after reg_rd |
| frame_start | input | 1 | Frame-boundary strobe, one cycle |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 24 | Registered RGB colour for the index |

## Verification
The assertions check on every cycle that the status bit changes only on a frame-boundary strobe and that each strobe leaves status equal to the request bit. They also check that a table write never targets the displayed bank and that control reads return the live request and status bits. Only the bench's scenarios can show that the palette contents come out correctly packed and with the correct latency. The same holds for the switch in colour source after a swap, for the displayed colours staying intact while the hidden bank is refilled, and for stray addresses being ignored.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_CTRL  = 2'd1,
    ACC_TABLE = 2'd2
  } acc_kind_e;

  localparam int REQ_BIT  = 0;
  localparam int STAT_BIT = 1;
endpackage

// File: rtl/pal_decode.sv
module pal_decode
  import palette_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int IDX_W     = 8,
  parameter int TBL_BASE  = 1024,
  parameter int CTRL_ADDR = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  index
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int TBL_END = TBL_BASE + 4 * DEPTH;

  function automatic acc_kind_e classify(input logic [ADDR_W-1:0] a);
    int ai;
    ai = int'(a);
    if (ai == CTRL_ADDR)
      return ACC_CTRL;
    if (ai >= TBL_BASE && ai < TBL_END && a[1:0] == 2'b00)
      return ACC_TABLE;
    return ACC_NONE;
  endfunction

  assign kind  = classify(addr);
  assign index = addr[IDX_W+1:2];
endmodule

// File: rtl/pal_swap_ctrl.sv
module pal_swap_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_we,
  input  logic req_in,
  input  logic frame_start,
  output logic req_bit,
  output logic stat_bit,
  output logic swap_evt
);
  assign swap_evt = frame_start && (req_bit != stat_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_bit  <= 1'b0;
      stat_bit <= 1'b0;
    end else begin
      if (ctrl_we)
        req_bit <= req_in;
      if (swap_evt)
        stat_bit <= req_bit;
    end
  end
endmodule

// File: rtl/pal_bank_mem.sv
module pal_bank_mem #(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               we,
  input  logic               wbank,
  input  logic [IDX_W-1:0]   widx,
  input  logic [COLOR_W-1:0] wdata,
  input  logic               disp_bank,
  input  logic [IDX_W-1:0]   disp_idx,
  output logic [COLOR_W-1:0] disp_data,
  input  logic               host_bank,
  input  logic [IDX_W-1:0]   host_idx,
  output logic [COLOR_W-1:0] host_data
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NBANKS = 2;

  logic [COLOR_W-1:0] disp_rd [NBANKS];
  logic [COLOR_W-1:0] host_rd [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [COLOR_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we && (wbank == 1'(b)))
        store[widx] <= wdata;
    end

    assign disp_rd[b] = store[disp_idx];
    assign host_rd[b] = store[host_idx];
  end

  assign disp_data = disp_rd[disp_bank];
  assign host_data = host_rd[host_bank];
endmodule

// File: rtl/palette_dbuf.sv
module palette_dbuf
  import palette_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int COLOR_W   = 24,
  parameter int ADDR_W    = 11,
  parameter int TBL_BASE  = 1024,
  parameter int CTRL_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [COLOR_W-1:0] reg_wdata,
  output logic [COLOR_W-1:0] reg_rdata,
  input  logic               frame_start,
  input  logic [IDX_W-1:0]   pix_idx,
  output logic [COLOR_W-1:0] pix_rgb
);
  acc_kind_e          acc_kind;
  logic [IDX_W-1:0]   acc_idx;
  logic               ctrl_we;
  logic               tbl_we;
  logic               ctrl_rd;
  logic               req_bit;
  logic               stat_bit;
  logic               swap_evt;
  logic               wr_bank;
  logic [COLOR_W-1:0] disp_data;
  logic [COLOR_W-1:0] host_data;

  function automatic logic [COLOR_W-1:0] ctrl_word(input logic st, input logic rq);
    logic [COLOR_W-1:0] w;
    w = '0;
    w[STAT_BIT] = st;
    w[REQ_BIT]  = rq;
    return w;
  endfunction

  pal_decode #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .TBL_BASE (TBL_BASE),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr (reg_addr),
    .kind (acc_kind),
    .index(acc_idx)
  );

  assign ctrl_we = reg_wr && (acc_kind == ACC_CTRL);
  assign tbl_we  = reg_wr && (acc_kind == ACC_TABLE);
  assign ctrl_rd = reg_rd && (acc_kind == ACC_CTRL);
  assign wr_bank = ~stat_bit;

  pal_swap_ctrl u_swap (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .req_in     (reg_wdata[REQ_BIT]),
    .frame_start(frame_start),
    .req_bit    (req_bit),
    .stat_bit   (stat_bit),
    .swap_evt   (swap_evt)
  );

  pal_bank_mem #(
    .IDX_W  (IDX_W),
    .COLOR_W(COLOR_W)
  ) u_mem (
    .clk      (clk),
    .we       (tbl_we),
    .wbank    (wr_bank),
    .widx     (acc_idx),
    .wdata    (reg_wdata),
    .disp_bank(stat_bit),
    .disp_idx (pix_idx),
    .disp_data(disp_data),
    .host_bank(wr_bank),
    .host_idx (acc_idx),
    .host_data(host_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_rgb   <= '0;
      reg_rdata <= '0;
    end else begin
      pix_rgb <= disp_data;
      if (reg_rd) begin
        unique case (acc_kind)
          ACC_CTRL:  reg_rdata <= ctrl_word(stat_bit, req_bit);
          ACC_TABLE: reg_rdata <= host_data;
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pal_dbuf_chk.sv
module pal_dbuf_chk #(
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_start,
  input logic               req_bit,
  input logic               stat_bit,
  input logic               swap_evt,
  input logic               tbl_we,
  input logic               wr_bank,
  input logic               ctrl_rd,
  input logic [COLOR_W-1:0] reg_rdata
);
  AST_STATUS_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    (stat_bit != $past(stat_bit)) |-> $past(frame_start)); // R5

  AST_FRAME_ADOPTS_REQ: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (stat_bit == $past(req_bit))); // R6

  AST_IDLE_FRAME_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !swap_evt) |=> $stable(stat_bit)); // R7

  AST_WRITE_HIDDEN_BANK: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> (wr_bank != stat_bit)); // R4

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> (reg_rdata == {{(COLOR_W-2){1'b0}}, $past(stat_bit), $past(req_bit)})); // R8
endmodule

bind palette_dbuf pal_dbuf_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_start(frame_start),
  .req_bit    (req_bit),
  .stat_bit   (stat_bit),
  .swap_evt   (swap_evt),
  .tbl_we     (tbl_we),
  .wr_bank    (wr_bank),
  .ctrl_rd    (ctrl_rd),
  .reg_rdata  (reg_rdata)
);

// File: tb/tb_palette_dbuf.sv
module tb_palette_dbuf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [10:0] reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        frame_start = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  palette_dbuf dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_start(frame_start), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  function automatic logic [23:0] pal_a(input int n);
    logic [7:0] b;
    b = 8'(n);
    return {b, ~b, b ^ 8'h5a};
  endfunction

  function automatic logic [23:0] pal_b(input int n);
    logic [7:0] b;
    b = 8'(n);
    return {b ^ 8'hc3, 8'(b * 3), 8'h11 + b};
  endfunction

  function automatic logic [10:0] entry_addr(input int n);
    return 11'(1024 + 4 * n);
  endfunction

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [23:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pix_check(input string req, input int n, input logic [23:0] exp);
    @(negedge clk);
    pix_idx = 8'(n);
    @(negedge clk);
    check(req, pix_rgb, exp);
  endtask

  task automatic t_reset();
    logic [23:0] d;
    rd(11'h000, d);
    check("R1 ctrl after reset", d, 24'h0);
  endtask

  task automatic t_fill_hidden();
    logic [23:0] d;
    for (int n = 0; n < 256; n++) wr(entry_addr(n), pal_a(n));
    rd(entry_addr(0), d);   check("R2 readback 0", d, pal_a(0));
    rd(entry_addr(77), d);  check("R2 readback 77", d, pal_a(77));
    rd(entry_addr(255), d); check("R2 readback 255", d, pal_a(255));
  endtask

  task automatic t_first_swap();
    logic [23:0] d;
    wr(11'h000, 24'h1);
    rd(11'h000, d);
    check("R5 request set, status held", d, 24'h1);
    frame();
    rd(11'h000, d);
    check("R6 status follows request", d, 24'h3);
    for (int n = 0; n < 256; n++) pix_check("R3 lookup bank1", n, pal_a(n));
  endtask

  task automatic t_refill_no_disturb();
    logic [23:0] d;
    for (int n = 0; n < 256; n++) wr(entry_addr(n), pal_b(n));
    rd(entry_addr(9), d);
    check("R2 hidden bank0 readback", d, pal_b(9));
    pix_check("R4 display intact 0", 0, pal_a(0));
    pix_check("R4 display intact 9", 9, pal_a(9));
    pix_check("R4 display intact 200", 200, pal_a(200));
  endtask

  task automatic t_idle_frame();
    logic [23:0] d;
    frame();
    rd(11'h000, d);
    check("R7 idle frame ctrl", d, 24'h3);
    pix_check("R7 idle frame display", 42, pal_a(42));
  endtask

  task automatic t_status_readonly();
    logic [23:0] d;
    wr(11'h000, 24'h3);
    rd(11'h000, d);
    check("R8 status not writable", d, 24'h3);
    frame();
    rd(11'h000, d);
    check("R8 ctrl after no-op write", d, 24'h3);
  endtask

  task automatic t_second_swap();
    logic [23:0] d;
    wr(11'h000, 24'hfffffe);
    rd(11'h000, d);
    check("R8 ctrl pending swap", d, 24'h2);
    pix_check("R5 no swap before frame", 5, pal_a(5));
    frame();
    rd(11'h000, d);
    check("R6 back to bank0", d, 24'h0);
    pix_check("R6 bank0 0", 0, pal_b(0));
    pix_check("R6 bank0 128", 128, pal_b(128));
    pix_check("R6 bank0 255", 255, pal_b(255));
  endtask

  task automatic t_stray_addr();
    logic [23:0] d;
    wr(entry_addr(1) + 11'd1, 24'hdeadbe);
    wr(11'h200, 24'h0badd1);
    wr(11'h004, 24'h000001);
    rd(entry_addr(1), d);
    check("R9 unaligned write ignored", d, pal_a(1));
    rd(11'h200, d);
    check("R9 stray read zero", d, 24'h0);
    rd(11'h000, d);
    check("R9 ctrl untouched", d, 24'h0);
    pix_check("R9 display untouched", 1, pal_b(1));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_hidden();
    t_first_swap();
    t_refill_no_disturb();
    t_idle_frame();
    t_status_readonly();
    t_second_swap();
    t_stray_addr();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule